// File: doc/BRIEF.md
# Bus tenure timeout monitor

This block watches a split-transaction system bus whose address and data phases are separate tenures, and catches any tenure that runs too long. Two independent timers are kept: one runs from transfer start to address acknowledge, the other from the rising edge of data-bus-busy to the final transfer acknowledge of that data tenure. Each window is programmed in units of 128 clocks through a small register port. A value of zero turns that timer off.

Each timer has its own error enable. When an enabled timer expires, the block pulses the matching abort output for one clock to end the stalled tenure. In the same cycle it sets a sticky event bit, which software clears by writing 1 to it. If no event bit was set at that moment, the block also captures the address and attributes of the offending tenure. When a timer expires with its enable clear, the expiry is treated as a non-error event: it is not reported, nothing is captured, and the tenure is left alone.

Register map on `reg_addr_i`:
- Word 0: address limit in bits [31:16] and data limit in bits [15:0].
- Word 1: address-timeout enable in bit 0 and data-timeout enable in bit 1.
- Word 2 (status): address event in bit 0 and data event in bit 1, both write-1-to-clear. Bit 4 holds the capture source, 0 for the address tenure and 1 for the data tenure. Bits [15:8] hold the captured attributes.
- Word 3: the captured address.

A data tenure is tagged with the address of the most recent transfer start. When transfer start arrives in the same cycle as the data tenure begins, the tag is the address on `addr_i` in that cycle.

Top module: `bus_tenure_watchdog`

## Requirements
- R1: After reset, register words 0 to 3 read as zero and both abort outputs are low.
- R2: With an address limit N > 0 and the address enable set, `addr_abort_o` is high for exactly one cycle. That cycle follows the clock edge that comes N*128 edges after the edge that sampled `ts_i`. If `aack_i` is sampled at or before that edge, no abort occurs.
- R3: With a data limit N > 0 and the data enable set, `data_abort_o` is high for exactly one cycle. That cycle follows the edge that comes N*128 edges after the edge where `dbb_i` is first sampled high. If `ta_last_i` is sampled at or before that edge, no abort occurs.
- R4: A limit of zero disables its timer, so no abort or event is ever produced for that tenure.
- R5: When a timer expires with its enable bit clear, no abort pulse is produced, no event bit is set and nothing is captured.
- R6: An event bit (status bit 0 for address, bit 1 for data) becomes visible in the same cycle as its abort pulse. Writing 1 to the bit clears it. Writing 0 leaves it unchanged.
- R7: The address, the attributes and the source bit are captured only when an event occurs while both event bits are clear. Later events leave the capture unchanged.
- R8: When both timers expire in the same cycle with both event bits clear, both aborts pulse and both event bits set. The capture takes the address tenure, with source bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ts_i | input | 1 | Transfer start, marks the beginning of an address tenure |
| aack_i | input | 1 | Address acknowledge, ends the address tenure |
| addr_i | input | 32 | Transfer address, sampled with `ts_i` |
| attr_i | input | 8 | Transfer attributes, sampled with `ts_i` |
| dbb_i | input | 1 | Data bus busy; a rising level starts a data tenure |
| ta_last_i | input | 1 | Final transfer acknowledge, ends the data tenure |
| addr_abort_o | output | 1 | One-cycle pulse that ends a timed-out address tenure |
| data_abort_o | output | 1 | One-cycle pulse that ends a timed-out data tenure |
| reg_addr_i | input | 2 | Register word select |
| reg_we_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for the selected word |

## Verification
Two pairs of functions can land in the same cycle.

The first pair is the timers' own: an acknowledge can arrive on exactly the edge where the count completes. The bench sweeps the acknowledge across the edge before, the edge itself and the edge after the expiry point, for several limits. It expects an abort only in the last case, at an edge number it computes as N*128.

The second pair is the two timers expiring together. The bench starts an address tenure and a data tenure on the same edge with equal limits. It then expects both aborts in one cycle, both event bits set, and the capture pointing at the address tenure.

// File: rtl/tenure_mon_pkg.sv
// Package: shared widths, register word indices and the capture record type
// for the bus tenure timeout monitor.
package tenure_mon_pkg;

    localparam int ADDR_W    = 32;
    localparam int ATTR_W    = 8;
    localparam int REG_W     = 32;
    localparam int REG_AW    = 2;
    localparam int LIMIT_W   = 16;
    localparam int PRESCALE_W = 7;

    localparam logic [REG_AW-1:0] WORD_LIMITS = 2'd0;
    localparam logic [REG_AW-1:0] WORD_ENABLE = 2'd1;
    localparam logic [REG_AW-1:0] WORD_STATUS = 2'd2;
    localparam logic [REG_AW-1:0] WORD_CAPADR = 2'd3;

    localparam int STS_SRC_BIT = 4;
    localparam int STS_ATTR_LO = 8;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [ATTR_W-1:0] attr;
    } tenure_tag_t;

endpackage

// File: rtl/tenure_timer.sv
// Module: tenure_timer
// Measures one bus tenure in units of 2**PRESCALE_W clocks. A start pulse
// (re)arms the counters; an end pulse stops them. expire_o is high in the
// cycle whose closing edge is the limit*2**PRESCALE_W-th edge after start,
// unless end_i or a new start_i is present in that cycle.
// Assumes: limit_i == 0 means the timer never expires.
module tenure_timer #(
    parameter int LIMIT_W    = 16,
    parameter int PRESCALE_W = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [LIMIT_W-1:0] limit_i,
    input  logic               start_i,
    input  logic               end_i,
    output logic               active_o,
    output logic               expire_o
);

    localparam logic [PRESCALE_W-1:0] PRE_LAST = {PRESCALE_W{1'b1}};

    logic                  active_q;
    logic [PRESCALE_W-1:0] pre_q;
    logic [LIMIT_W-1:0]    units_q;
    logic                  last_unit;

    // Purpose: detect the final unit of the programmed window.
    always_comb begin
        last_unit = (limit_i != '0) && (units_q == limit_i - 1'b1);
        expire_o  = active_q && !end_i && !start_i && (pre_q == PRE_LAST) && last_unit;
    end

    // Purpose: advance prescaler and unit counter while a tenure is open.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            pre_q    <= '0;
            units_q  <= '0;
        end else if (start_i) begin
            active_q <= 1'b1;
            pre_q    <= '0;
            units_q  <= '0;
        end else if (active_q) begin
            if (end_i || expire_o) begin
                active_q <= 1'b0;
            end else begin
                pre_q <= pre_q + 1'b1;
                if (pre_q == PRE_LAST) begin
                    units_q <= units_q + 1'b1;
                end
            end
        end
    end

    assign active_o = active_q;

    p_no_expire_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (limit_i == '0) |-> !expire_o);
    p_expire_needs_run_r2: assert property (@(posedge clk) disable iff (!rst_n)
        expire_o |-> $past(active_q));
    p_closed_after_expire_r3: assert property (@(posedge clk) disable iff (!rst_n)
        expire_o |=> (!active_q || $past(start_i)));

endmodule

// File: rtl/tenure_event_log.sv
// Module: tenure_event_log
// Holds the sticky event bits (bit0 address, bit1 data) and the capture of
// the first error's tag. Set wins over a same-cycle write-1-to-clear.
// Assumes: fire inputs are already qualified by the error enables.
module tenure_event_log
    import tenure_mon_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        a_fire_i,
    input  logic        d_fire_i,
    input  tenure_tag_t a_tag_i,
    input  tenure_tag_t d_tag_i,
    input  logic [1:0]  clear_i,
    output logic [1:0]  event_o,
    output logic        cap_src_o,
    output tenure_tag_t cap_tag_o
);

    logic [1:0]  event_q;
    logic        src_q;
    tenure_tag_t tag_q;
    logic        take;

    // Purpose: capture is allowed only from the all-clear state.
    always_comb begin
        take = (event_q == 2'b00) && (a_fire_i || d_fire_i);
    end

    // Purpose: update sticky bits and the first-error record.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            event_q <= 2'b00;
            src_q   <= 1'b0;
            tag_q   <= '0;
        end else begin
            event_q <= (event_q & ~clear_i) | {d_fire_i, a_fire_i};
            if (take) begin
                src_q <= !a_fire_i;
                tag_q <= a_fire_i ? a_tag_i : d_tag_i;
            end
        end
    end

    assign event_o   = event_q;
    assign cap_src_o = src_q;
    assign cap_tag_o = tag_q;

    p_capture_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(event_q) != 2'b00) |-> ($stable(tag_q) && $stable(src_q)));
    p_addr_first_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (a_fire_i && d_fire_i && event_q == 2'b00) |=> !src_q);

endmodule

// File: rtl/tenure_regs.sv
// Module: tenure_regs
// Configuration words (limits, enables), write decode for the status
// clear, and the read multiplexer over all four words.
// Assumes: 2*LIMIT_W fits in REG_W; reads are combinational.
module tenure_regs
    import tenure_mon_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [REG_AW-1:0]  reg_addr_i,
    input  logic               reg_we_i,
    input  logic [REG_W-1:0]   reg_wdata_i,
    output logic [REG_W-1:0]   reg_rdata_o,
    output logic [LIMIT_W-1:0] a_limit_o,
    output logic [LIMIT_W-1:0] d_limit_o,
    output logic [1:0]         enable_o,
    output logic [1:0]         clear_o,
    input  logic [1:0]         event_i,
    input  logic               cap_src_i,
    input  tenure_tag_t        cap_tag_i
);

    logic [LIMIT_W-1:0] a_lim_q;
    logic [LIMIT_W-1:0] d_lim_q;
    logic [1:0]         en_q;

    // Purpose: store limits and enables on writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_lim_q <= '0;
            d_lim_q <= '0;
            en_q    <= 2'b00;
        end else if (reg_we_i) begin
            if (reg_addr_i == WORD_LIMITS) begin
                a_lim_q <= reg_wdata_i[2*LIMIT_W-1:LIMIT_W];
                d_lim_q <= reg_wdata_i[LIMIT_W-1:0];
            end
            if (reg_addr_i == WORD_ENABLE) begin
                en_q <= reg_wdata_i[1:0];
            end
        end
    end

    // Purpose: decode write-1-to-clear on the status word.
    always_comb begin
        clear_o = (reg_we_i && reg_addr_i == WORD_STATUS) ? reg_wdata_i[1:0] : 2'b00;
    end

    // Purpose: select read data.
    always_comb begin
        reg_rdata_o = '0;
        case (reg_addr_i)
            WORD_LIMITS: reg_rdata_o[2*LIMIT_W-1:0] = {a_lim_q, d_lim_q};
            WORD_ENABLE: reg_rdata_o[1:0] = en_q;
            WORD_STATUS: begin
                reg_rdata_o[1:0]         = event_i;
                reg_rdata_o[STS_SRC_BIT] = cap_src_i;
                reg_rdata_o[STS_ATTR_LO +: ATTR_W] = cap_tag_i.attr;
            end
            default:     reg_rdata_o[ADDR_W-1:0] = cap_tag_i.addr;
        endcase
    end

    assign a_limit_o = a_lim_q;
    assign d_limit_o = d_lim_q;
    assign enable_o  = en_q;

endmodule

// File: rtl/bus_tenure_watchdog.sv
// Module: bus_tenure_watchdog (top)
// Runs one tenure timer for the address phase (ts_i .. aack_i) and one for
// the data phase (rising dbb_i .. ta_last_i). Enabled expiries pulse the
// abort outputs for one cycle and feed the event log; disabled expiries are
// dropped silently. Data tenures carry the tag of the latest transfer start.
// Assumes: single clock domain, inputs synchronous to clk.
module bus_tenure_watchdog
    import tenure_mon_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ts_i,
    input  logic                aack_i,
    input  logic [ADDR_W-1:0]   addr_i,
    input  logic [ATTR_W-1:0]   attr_i,
    input  logic                dbb_i,
    input  logic                ta_last_i,
    output logic                addr_abort_o,
    output logic                data_abort_o,
    input  logic [REG_AW-1:0]   reg_addr_i,
    input  logic                reg_we_i,
    input  logic [REG_W-1:0]    reg_wdata_i,
    output logic [REG_W-1:0]    reg_rdata_o
);

    localparam int NUM_TIMERS = 2;

    logic [LIMIT_W-1:0] a_limit, d_limit;
    logic [1:0]         enable, clear, events;
    logic               cap_src;
    tenure_tag_t        cap_tag;

    logic               dbb_q;
    tenure_tag_t        a_tag_q, d_tag_q, last_tag_q, cur_tag;

    logic [NUM_TIMERS-1:0] t_start, t_end, t_active, t_expire, t_fire;
    logic [LIMIT_W-1:0]    t_limit [NUM_TIMERS];
    logic [1:0]            abort_q;

    // Purpose: present-cycle tag, bypassing the latch on a transfer start.
    always_comb begin
        cur_tag.addr = addr_i;
        cur_tag.attr = attr_i;
    end

    // Purpose: form start/end strobes and limits per timer.
    always_comb begin
        t_start[0] = ts_i;
        t_end[0]   = aack_i;
        t_limit[0] = a_limit;
        t_start[1] = dbb_i && !dbb_q;
        t_end[1]   = ta_last_i;
        t_limit[1] = d_limit;
        t_fire     = t_expire & enable;
    end

    generate
        for (genvar g = 0; g < NUM_TIMERS; g++) begin : g_timer
            tenure_timer #(
                .LIMIT_W   (LIMIT_W),
                .PRESCALE_W(PRESCALE_W)
            ) u_timer (
                .clk     (clk),
                .rst_n   (rst_n),
                .limit_i (t_limit[g]),
                .start_i (t_start[g]),
                .end_i   (t_end[g]),
                .active_o(t_active[g]),
                .expire_o(t_expire[g])
            );
        end
    endgenerate

    // Purpose: track dbb level and latch the tags of open tenures.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dbb_q      <= 1'b0;
            a_tag_q    <= '0;
            d_tag_q    <= '0;
            last_tag_q <= '0;
        end else begin
            dbb_q <= dbb_i;
            if (ts_i) begin
                a_tag_q    <= cur_tag;
                last_tag_q <= cur_tag;
            end
            if (t_start[1]) begin
                d_tag_q <= ts_i ? cur_tag : last_tag_q;
            end
        end
    end

    // Purpose: register the one-cycle abort pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            abort_q <= 2'b00;
        end else begin
            abort_q <= t_fire;
        end
    end

    tenure_event_log u_log (
        .clk      (clk),
        .rst_n    (rst_n),
        .a_fire_i (t_fire[0]),
        .d_fire_i (t_fire[1]),
        .a_tag_i  (a_tag_q),
        .d_tag_i  (d_tag_q),
        .clear_i  (clear),
        .event_o  (events),
        .cap_src_o(cap_src),
        .cap_tag_o(cap_tag)
    );

    tenure_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_addr_i (reg_addr_i),
        .reg_we_i   (reg_we_i),
        .reg_wdata_i(reg_wdata_i),
        .reg_rdata_o(reg_rdata_o),
        .a_limit_o  (a_limit),
        .d_limit_o  (d_limit),
        .enable_o   (enable),
        .clear_o    (clear),
        .event_i    (events),
        .cap_src_i  (cap_src),
        .cap_tag_i  (cap_tag)
    );

    assign addr_abort_o = abort_q[0];
    assign data_abort_o = abort_q[1];

    p_abort_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        addr_abort_o |=> !addr_abort_o);
    p_dabort_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        data_abort_o |=> !data_abort_o);
    p_abort_marks_event_r6: assert property (@(posedge clk) disable iff (!rst_n)
        addr_abort_o |-> events[0]);
    p_dabort_marks_event_r6: assert property (@(posedge clk) disable iff (!rst_n)
        data_abort_o |-> events[1]);
    p_masked_silent_r5: assert property (@(posedge clk) disable iff (!rst_n)
        addr_abort_o |-> $past(enable[0]));
    p_dmasked_silent_r5: assert property (@(posedge clk) disable iff (!rst_n)
        data_abort_o |-> $past(enable[1]));

endmodule

// File: tb/bus_tenure_watchdog_test.sv
module bus_tenure_watchdog_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ts_i = 1'b0, aack_i = 1'b0, dbb_i = 1'b0, ta_last_i = 1'b0;
    logic [31:0] addr_i = '0;
    logic [7:0]  attr_i = '0;
    logic        addr_abort_o, data_abort_o;
    logic [1:0]  reg_addr_i = '0;
    logic        reg_we_i = 1'b0;
    logic [31:0] reg_wdata_i = '0;
    logic [31:0] reg_rdata_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    bus_tenure_watchdog uut (
        .clk(clk), .rst_n(rst_n), .ts_i(ts_i), .aack_i(aack_i),
        .addr_i(addr_i), .attr_i(attr_i), .dbb_i(dbb_i), .ta_last_i(ta_last_i),
        .addr_abort_o(addr_abort_o), .data_abort_o(data_abort_o),
        .reg_addr_i(reg_addr_i), .reg_we_i(reg_we_i),
        .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr_i = a; reg_wdata_i = d; reg_we_i = 1'b1;
        @(posedge clk); #1;
        reg_we_i = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr_i = a;
        #0.5 d = reg_rdata_o;
    endtask

    // Opens a tenure (kind 0 address, 1 data, 2 both on one edge), ends it at
    // edge m (0 = never), and reports the first abort edge and pulse counts.
    task automatic run(input int kind, input int m, input int len,
                       input logic [31:0] a, input logic [7:0] at,
                       output int first_a, output int first_d,
                       output int cnt_a, output int cnt_d);
        first_a = 0; first_d = 0; cnt_a = 0; cnt_d = 0;
        @(negedge clk);
        addr_i = a; attr_i = at;
        ts_i  = 1'b1;
        dbb_i = (kind != 0);
        @(posedge clk); #1;
        for (int j = 1; j <= len; j++) begin
            @(negedge clk);
            ts_i      = 1'b0;
            aack_i    = (kind != 1) && (j == m);
            ta_last_i = (kind != 0) && (j == m);
            @(posedge clk); #1;
            if (addr_abort_o) begin cnt_a++; if (first_a == 0) first_a = j; end
            if (data_abort_o) begin cnt_d++; if (first_d == 0) first_d = j; end
        end
        @(negedge clk);
        aack_i = 1'b0; ta_last_i = 1'b0; dbb_i = 1'b0;
        repeat (2) @(posedge clk);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog run did not finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] r;
        int fa, fd, ca, cd, exp_first;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R1: reset state
        for (int w = 0; w < 4; w++) begin
            rd(w[1:0], r);
            check("R1", "reset word", r, 32'h0);
        end
        check("R1", "aborts after reset", {30'b0, addr_abort_o, data_abort_o}, 32'h0);

        // R4: zero limits (reset value) -> nothing ever fires
        wr(2'd1, 32'h3);
        run(2, 0, 300, 32'hAAAA_0000, 8'h11, fa, fd, ca, cd);
        check("R4", "no abort with zero limit", ca + cd, 0);
        rd(2'd2, r); check("R4", "no event with zero limit", r[1:0], 0);

        // R2 / R6 / R7: address window sweep
        for (int n = 1; n <= 3; n++) begin
            for (int k = 0; k < 4; k++) begin
                int m;
                m = (k == 0) ? 0 : n * 128 - 2 + k;
                wr(2'd0, n << 16);
                run(0, m, n * 128 + 4, 32'h1000_0000 + n * 16 + k, 8'(8'h40 + k), fa, fd, ca, cd);
                exp_first = (m != 0 && m <= n * 128) ? 0 : n * 128;
                check("R2", "address abort edge", fa, exp_first);
                check("R2", "address abort width", ca, (exp_first != 0) ? 1 : 0);
                rd(2'd2, r);
                check("R6", "address event bit", r[1:0], (exp_first != 0) ? 2'b01 : 2'b00);
                if (exp_first != 0) begin
                    check("R7", "captured attr", r[15:8], 8'h40 + k);
                    check("R7", "capture source", r[4], 0);
                    rd(2'd3, r);
                    check("R7", "captured address", r, 32'h1000_0000 + n * 16 + k);
                end
                wr(2'd2, 32'h0);
                rd(2'd2, r);
                check("R6", "write 0 keeps event", r[0], (exp_first != 0));
                wr(2'd2, 32'h1);
                rd(2'd2, r);
                check("R6", "write 1 clears event", r[1:0], 0);
            end
        end

        // R3: data window sweep, address timer off
        for (int n = 1; n <= 2; n++) begin
            for (int k = 0; k < 4; k++) begin
                int m;
                m = (k == 0) ? 0 : n * 128 - 2 + k;
                wr(2'd0, n);
                run(1, m, n * 128 + 4, 32'h2000_0000 + k, 8'h5A, fa, fd, ca, cd);
                exp_first = (m != 0 && m <= n * 128) ? 0 : n * 128;
                check("R3", "data abort edge", fd, exp_first);
                check("R3", "data abort width", cd, (exp_first != 0) ? 1 : 0);
                check("R3", "no address abort", ca, 0);
                rd(2'd2, r);
                check("R6", "data event bit", r[1:0], (exp_first != 0) ? 2'b10 : 2'b00);
                if (exp_first != 0) begin
                    check("R7", "data capture source", r[4], 1);
                    rd(2'd3, r);
                    check("R7", "data tenure tag", r, 32'h2000_0000 + k);
                end
                wr(2'd2, 32'h3);
            end
        end

        // R5: enables off, timers still expire silently
        wr(2'd1, 32'h0);
        wr(2'd0, 32'h0001_0001);
        run(2, 0, 140, 32'h3000_0000, 8'h22, fa, fd, ca, cd);
        check("R5", "no abort when disabled", ca + cd, 0);
        rd(2'd2, r); check("R5", "no event when disabled", r[1:0], 0);
        rd(2'd3, r); check("R5", "capture untouched", r, 32'h2000_0003);

        // R8: both expire on one edge
        wr(2'd1, 32'h3);
        run(2, 0, 132, 32'h4444_0000, 8'h77, fa, fd, ca, cd);
        check("R8", "address abort edge", fa, 128);
        check("R8", "data abort same edge", fd, 128);
        rd(2'd2, r);
        check("R8", "both event bits", r[1:0], 2'b11);
        check("R8", "source is address", r[4], 0);
        rd(2'd3, r); check("R8", "captured address", r, 32'h4444_0000);

        // R7: a later error must not overwrite the capture
        wr(2'd2, 32'h2);
        run(0, 0, 132, 32'h5555_0000, 8'h99, fa, fd, ca, cd);
        check("R7", "second abort occurs", fa, 128);
        rd(2'd3, r); check("R7", "capture kept", r, 32'h4444_0000);
        wr(2'd2, 32'h3);
        rd(2'd2, r); check("R6", "all cleared", r[1:0], 0);

        // R1: register readback of configuration layout
        rd(2'd0, r); check("R1", "limits word", r, 32'h0001_0001);
        rd(2'd1, r); check("R1", "enable word", r, 32'h3);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule